// File: doc/BRIEF.md
# Random Word Pacer with Event Interrupt

This block is the register-side control of a random number peripheral. An upstream conditioning stage, which is not part of this block, hands over a batch of four 32-bit words at a time. The block decides when a batch may be taken and holds it in a four-word buffer. Software then drains the buffer through a small register port, one word per read. Batches are rate limited. The gap between two takes is sixteen times the bus-to-generator clock ratio, counted in bus cycles, with a floor of 213 bus cycles. The first batch after enable waits longer. One of two first-batch latencies is chosen by a mode input at the moment the enable bit is set.

Three flags can request an interrupt: data ready, seed error and clock error. One interrupt-enable bit gates all three onto a single interrupt line, and the line stays low while the peripheral is disabled. Data ready has no software clear and falls when the last buffered word has been read. The two error flags are cleared by writing 0 to them. A seed error flushes the buffer and stops further takes until software clears the flag and then enables the peripheral again.

Top module: `rng_pacer`

## Requirements
- R1: After reset, the control register (address 0: bit0 enable, bit1 interrupt enable) reads 0, the status register (address 1: bit0 data ready, bit1 seed error, bit2 clock error) reads 0, and `irq` and `cond_take` are low.
- R2: When a control write sets the enable bit for the first time since reset, `cond_take` goes high exactly L bus cycles after the write edge. L is 128*CLK_RATIO+426 when `first_sel` is 0 and 192*CLK_RATIO+213 when it is 1.
- R3: When the buffer is empty in time, consecutive `cond_take` pulses are exactly max(16*CLK_RATIO, 213) cycles apart.
- R4: A read of the data register (address 2) returns the buffered words in batch order, word 0 first (bits 31:0 of `cond_batch`), and each such read removes one word.
- R5: Data ready is 1 while at least one word is unread and drops after the fourth read. A data read with an empty buffer returns 0.
- R6: A seed-error event sets status bit1 and empties the buffer. No batch is then taken until bit1 has been cleared and the enable bit has gone from 0 to 1. After that re-enable, the next take follows after the pass interval.
- R7: A clock-error event sets status bit2 and does not stop the pacing of batches.
- R8: Writing 0 to status bit1 or bit2 clears that flag. Writing 1 leaves it unchanged. An error event in the same cycle as a clearing write leaves the flag set.
- R9: `irq` is high exactly when enable and interrupt enable are both 1 and at least one of the three flags is set. With either control bit at 0 it stays low.
- R10: If the pass interval expires while words are still unread, the next take happens in the cycle right after the last word is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on a data read) |
| reg_wbits | input | 3 | Write data for the writable bit positions |
| reg_rdata | output | 32 | Read data, combinational from the address |
| first_sel | input | 1 | Selects the first-batch latency case |
| seed_err_evt | input | 1 | Seed-error event pulse |
| clk_err_evt | input | 1 | Clock-error event pulse |
| cond_batch | input | 128 | Four conditioned words, word 0 in the low bits |
| cond_take | output | 1 | The batch is captured at the end of this cycle |
| irq | output | 1 | Interrupt request |

## Verification
The in-line properties are checked on every cycle. They cover the buffer flush after a seed-error event, the one-word drop per data read, the rule that data ready falls only after a read or a flush, and the ban on takes while a seed error is pending. They also cover the behaviour of the clock-error flag under a write of 1 and under an event that coincides with a clearing write. Only the bench's scenarios can show the exact first-batch latency in both modes, the spacing between takes, the word order against the scoreboard, the take that follows a late drain, and the re-enable sequence that lifts a seed-error block.

// File: rtl/rng_pacer.sv
module rng_pacer #(
  parameter int DW          = 32,
  parameter int WORDS       = 4,
  parameter int CLK_RATIO   = 4,
  parameter int PASS_MULT   = 16,
  parameter int MIN_GAP     = 213,
  parameter int FIRST_RNG_A = 128,
  parameter int FIRST_BUS_A = 426,
  parameter int FIRST_RNG_B = 192,
  parameter int FIRST_BUS_B = 213
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          reg_addr,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [2:0]          reg_wbits,
  output logic [DW-1:0]       reg_rdata,
  input  logic                first_sel,
  input  logic                seed_err_evt,
  input  logic                clk_err_evt,
  input  logic [WORDS*DW-1:0] cond_batch,
  output logic                cond_take,
  output logic                irq
);

  localparam int PASS_RAW = PASS_MULT * CLK_RATIO;
  localparam int PASS     = (PASS_RAW > MIN_GAP) ? PASS_RAW : MIN_GAP;
  localparam int LAT_A    = FIRST_RNG_A * CLK_RATIO + FIRST_BUS_A;
  localparam int LAT_B    = FIRST_RNG_B * CLK_RATIO + FIRST_BUS_B;
  localparam int LAT_AB   = (LAT_A > LAT_B) ? LAT_A : LAT_B;
  localparam int LAT_MAX  = (LAT_AB > PASS) ? LAT_AB : PASS;
  localparam int TW       = $clog2(LAT_MAX + 1);
  localparam int CW       = $clog2(WORDS + 1);
  localparam int PW       = (WORDS > 1) ? $clog2(WORDS) : 1;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  logic          en, ie, seis, ceis, blk, primed;
  logic [TW-1:0] timer;
  logic [CW-1:0] cnt;
  logic [PW-1:0] rp;
  logic [DW-1:0] wbuf [WORDS];

  logic wr_ctrl, wr_stat, en_rise, pop, drdy;

  assign wr_ctrl = reg_wr && reg_addr == A_CTRL;
  assign wr_stat = reg_wr && reg_addr == A_STAT;
  assign en_rise = wr_ctrl && reg_wbits[0] && !en;
  assign pop     = reg_rd && reg_addr == A_DATA && cnt != '0;
  assign drdy    = cnt != '0;

  assign cond_take = en && !blk && !seed_err_evt && timer == '0 && cnt == '0;
  assign irq       = en && ie && (drdy || seis || ceis);

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {{(DW-2){1'b0}}, ie, en};
      A_STAT:  reg_rdata = {{(DW-3){1'b0}}, ceis, seis, drdy};
      A_DATA:  reg_rdata = drdy ? wbuf[rp] : '0;
      default: reg_rdata = '0;
    endcase
  end

  // control, flags and the seed-error block
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      ie     <= 1'b0;
      seis   <= 1'b0;
      ceis   <= 1'b0;
      blk    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en <= reg_wbits[0];
        ie <= reg_wbits[1];
      end
      seis <= seed_err_evt || (seis && !(wr_stat && !reg_wbits[1]));
      ceis <= clk_err_evt  || (ceis && !(wr_stat && !reg_wbits[2]));
      if (seed_err_evt)
        blk <= 1'b1;
      else if (en_rise && !seis)
        blk <= 1'b0;
    end
  end

  // pass timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer  <= '0;
      primed <= 1'b0;
    end else if (en_rise) begin
      primed <= 1'b1;
      if (primed)
        timer <= TW'(PASS);
      else
        timer <= first_sel ? TW'(LAT_B) : TW'(LAT_A);
    end else if (cond_take) begin
      timer <= TW'(PASS - 1);
    end else if (en && !blk && timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  // output buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      rp  <= '0;
      for (int i = 0; i < WORDS; i++) wbuf[i] <= '0;
    end else if (seed_err_evt) begin
      cnt <= '0;
      rp  <= '0;
    end else if (cond_take) begin
      cnt <= CW'(WORDS);
      rp  <= '0;
      for (int i = 0; i < WORDS; i++) wbuf[i] <= cond_batch[i*DW +: DW];
    end else if (pop) begin
      cnt <= cnt - 1'b1;
      rp  <= rp + 1'b1;
    end
  end

  // R6
  seed_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_err_evt |=> (cnt == '0 && seis));

  // R6
  seed_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seis |-> !cond_take);

  // R4
  pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !seed_err_evt) |=> (cnt + 1'b1) == $past(cnt));

  // R5
  drdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy) |-> ($past(pop) || $past(seed_err_evt)));

  // R8
  w1_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wbits[2] && !clk_err_evt) |=> ceis == $past(ceis));

  // R8
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_err_evt |=> ceis);

  // R3
  take_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_take |=> !cond_take);

endmodule

// File: tb/test_rng_pacer.sv
module test_rng_pacer;
  localparam int DW = 32, WORDS = 4, RATIO = 4;
  localparam int PASS  = (16*RATIO > 213) ? 16*RATIO : 213;
  localparam int LAT_A = 128*RATIO + 426;
  localparam int LAT_B = 192*RATIO + 213;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_wbits = '0;
  logic [DW-1:0] reg_rdata;
  logic first_sel = 1'b0, seed_err_evt = 1'b0, clk_err_evt = 1'b0;
  logic [WORDS*DW-1:0] cond_batch;
  logic cond_take, irq;

  int checks = 0, errors = 0, cyc = 0;
  int take_cnt = 0, take_last = 0, take_prev = 0, en_cyc = 0, base = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] exp_q [$];
  logic [31:0] d;

  always #10 clk = ~clk;

  rng_pacer #(.DW(DW), .WORDS(WORDS), .CLK_RATIO(RATIO)) i_rng_pacer (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wbits(reg_wbits), .reg_rdata(reg_rdata), .first_sel(first_sel),
    .seed_err_evt(seed_err_evt), .clk_err_evt(clk_err_evt), .cond_batch(cond_batch),
    .cond_take(cond_take), .irq(irq));

  always_comb
    for (int i = 0; i < WORDS; i++)
      cond_batch[i*DW +: DW] = seed ^ (32'h9E37_79B9 * (i + 1));

  // conditioning stub and scoreboard driver
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cond_take) begin
      for (int i = 0; i < WORDS; i++) exp_q.push_back(cond_batch[i*DW +: DW]);
      seed <= seed * 32'd1664525 + 32'd1013904223;
    end
  end

  always @(negedge clk)
    if (rst_n && cond_take) begin
      take_prev = take_last;
      take_last = cyc;
      take_cnt++;
    end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [2:0] v);
    @(negedge clk); reg_addr = a; reg_wbits = v; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(posedge clk);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  // scoreboard monitor: one data read, compared with the queue head
  task automatic rd_word(input string req);
    logic [31:0] v, e;
    rd(2'd2, v);
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'h0;
    chk(v == e, req, v, e);
  endtask

  task automatic wait_take(input int target);
    while (take_cnt < target) begin @(negedge clk); #1; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    take_cnt = 0;
    exp_q.delete();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    do_reset();
    // R1
    rd(2'd0, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(2'd1, d); chk(d == 0, "R1 status", d, 0);
    chk(!irq && !cond_take, "R1 outputs", {irq, cond_take}, 0);

    // R2 mode 0
    first_sel = 1'b0;
    wr(2'd0, 3'b011); en_cyc = cyc;
    wait_take(1);
    chk(take_last - en_cyc == LAT_A, "R2 first latency mode0", take_last - en_cyc, LAT_A);
    @(negedge clk); #1;
    rd(2'd1, d); chk(d[0] == 1'b1, "R5 drdy set", d, 1);
    chk(irq == 1'b1, "R9 irq on drdy", irq, 1);

    // R4 / R5 drain
    rd_word("R4 word0"); rd_word("R4 word1"); rd_word("R4 word2");
    rd(2'd1, d); chk(d[0] == 1'b1, "R5 drdy with one left", d, 1);
    rd_word("R4 word3");
    rd(2'd1, d); chk(d[0] == 1'b0, "R5 drdy cleared", d, 0);
    rd(2'd2, d); chk(d == 0, "R5 empty read", d, 0);
    chk(irq == 1'b0, "R9 irq idle", irq, 0);

    // R3 pass interval
    wait_take(2);
    chk(take_last - take_prev == PASS, "R3 pass interval", take_last - take_prev, PASS);

    // R10 late drain
    base = take_cnt;
    repeat (PASS + 20) @(negedge clk);
    #1 chk(take_cnt == base, "R10 hold while full", take_cnt, base);
    rd_word("R4 b2w0"); rd_word("R4 b2w1"); rd_word("R4 b2w2"); rd_word("R4 b2w3");
    #1 chk(take_cnt == base + 1, "R10 take after last read", take_cnt, base + 1);

    // R9 gating
    wr(2'd0, 3'b001); #1 chk(irq == 1'b0, "R9 ie off", irq, 0);
    wr(2'd0, 3'b010); #1 chk(irq == 1'b0, "R9 en off", irq, 0);
    wr(2'd0, 3'b011); #1 chk(irq == 1'b1, "R9 both on", irq, 1);

    // R7 / R8 clock error
    @(negedge clk); clk_err_evt = 1'b1;
    @(negedge clk); clk_err_evt = 1'b0;
    rd(2'd1, d); chk(d[2] == 1'b1, "R7 clock flag set", d, 4);
    wr(2'd1, 3'b100);
    rd(2'd1, d); chk(d[2] == 1'b1, "R8 write one keeps", d, 4);
    @(negedge clk); reg_addr = 2'd1; reg_wbits = 3'b000; reg_wr = 1'b1; clk_err_evt = 1'b1;
    @(negedge clk); reg_wr = 1'b0; clk_err_evt = 1'b0;
    rd(2'd1, d); chk(d[2] == 1'b1, "R8 event wins", d, 4);
    wr(2'd1, 3'b000);
    rd(2'd1, d); chk(d[2] == 1'b0, "R8 write zero clears", d, 0);
    base = take_cnt;
    rd_word("R4 b3w0"); rd_word("R4 b3w1"); rd_word("R4 b3w2"); rd_word("R4 b3w3");
    wait_take(base + 1);
    chk(take_cnt == base + 1, "R7 pacing continues", take_cnt, base + 1);
    @(negedge clk);

    // R6 seed error
    @(negedge clk); seed_err_evt = 1'b1;
    @(negedge clk); seed_err_evt = 1'b0; exp_q.delete();
    rd(2'd1, d); chk(d[1:0] == 2'b10, "R6 flag set and flushed", d, 2);
    chk(irq == 1'b1, "R9 irq on seed error", irq, 1);
    base = take_cnt;
    repeat (2*PASS) @(negedge clk);
    #1 chk(take_cnt == base, "R6 blocked while flagged", take_cnt, base);
    wr(2'd1, 3'b000);
    rd(2'd1, d); chk(d[1] == 1'b0, "R8 seed flag cleared", d, 0);
    repeat (PASS + 10) @(negedge clk);
    #1 chk(take_cnt == base, "R6 blocked until re-enable", take_cnt, base);
    wr(2'd0, 3'b000);
    wr(2'd0, 3'b011); en_cyc = cyc;
    wait_take(base + 1);
    chk(take_last - en_cyc == PASS, "R6 resume after re-enable", take_last - en_cyc, PASS);
    @(negedge clk);
    rd_word("R4 b4w0"); rd_word("R4 b4w1"); rd_word("R4 b4w2"); rd_word("R4 b4w3");

    // R2 mode 1
    do_reset();
    first_sel = 1'b1;
    wr(2'd0, 3'b001); en_cyc = cyc;
    first_sel = 1'b0;
    wait_take(1);
    chk(take_last - en_cyc == LAT_B, "R2 first latency mode1", take_last - en_cyc, LAT_B);
    @(negedge clk);
    rd_word("R4 mode1 w0");

    finish_run();
  end
endmodule